// File: doc/BRIEF.md
# Stereo Pixel Splicing Read Port

This block answers read transfers from a 32-bit local bus bridge in a two-camera capture path. Each camera writes its pixels into one of two ping-pong banks, and a shared bank-select signal names the bank currently being filled. The read port always reads the other bank of each camera. The left and right pixel stored at the same word address are joined into one bus word, so both halves of every word show the same image coordinate.

A seven-state machine follows the bridge's active-low address strobe and active-low burst-last signal. It tells a single transfer apart from a burst, pulses an active-low ready for each data beat, and steps the word address once per burst beat. A simple hold request is answered with a hold acknowledge one cycle later. No arbitration or DMA setup is handled here.

Top module: `stereo_splice_rd`

## Requirements
- R1: While reset is held and after it is released with no strobe, `rdy_n` is 1, `hold_ack` is 0, `bus_data` is 0 and `mem_addr` is 0.
- R2: `hold_ack` equals the value `hold_req` had at the previous clock edge.
- R3: If `ads_n` is low at an edge while idle, the machine enters start. If `blast_n` is low in start, the next cycle is the single data beat with `rdy_n` low. The cycle after that is the end state.
- R4: If `blast_n` is high in start, one wait cycle with `rdy_n` high follows. Then there is one beat per cycle with `rdy_n` low while `blast_n` stays high. The beat in which `blast_n` is low is the last one. It is followed by a burst-end cycle and then the end state, both with `rdy_n` high.
- R5: `bus_addr` is captured as a word address at the accepted strobe edge and appears on `mem_addr`. Each burst beat advances `mem_addr` by one in the following cycle, wrapping at the address width.
- R6: During a read beat, `bus_data[15:0]` is the left pixel and `bus_data[31:16]` is the right pixel, both read at `mem_addr`.
- R7: The bank read is the one opposite `bank_sel`. With `bank_sel` = 1 the bank-0 inputs are used, and with `bank_sel` = 0 the bank-1 inputs are used.
- R8: If `ads_n` is low in the end state, the next transfer starts at once at start with the new address. Otherwise the machine returns to idle.
- R9: A transfer whose `wr_rd` was 0 at the strobe edge (a write) still gets its `rdy_n` beats, but `bus_data` stays 0.
- R10: Outside data beats, `bus_data` is 0 and `rdy_n` is 1. A low `ads_n` in any state other than idle or end is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_req | input | 1 | Local bus hold request |
| hold_ack | output | 1 | Hold acknowledge, one cycle after the request |
| ads_n | input | 1 | Address strobe, active low |
| blast_n | input | 1 | Burst-last indicator, active low |
| wr_rd | input | 1 | Direction, 1 = read |
| bus_addr | input | 18 | Word address from the bus |
| bank_sel | input | 1 | Bank being written (1 = bank 1) |
| left_b0 | input | 16 | Left camera, bank 0 read data |
| left_b1 | input | 16 | Left camera, bank 1 read data |
| right_b0 | input | 16 | Right camera, bank 0 read data |
| right_b1 | input | 16 | Right camera, bank 1 read data |
| mem_addr | output | 18 | Word address shared by all banks |
| bus_data | output | 32 | Spliced read word |
| rdy_n | output | 1 | Data valid on the bus, active low |

## Verification
The bench runs back-to-back transfers in which the strobe arrives in the end state. A design that routes end to idle would lose a cycle there and shift every later beat. It runs bursts of one beat, of several beats, and one that wraps at the top address. An off-by-one in the address step would return the neighbouring pixel, and a late burst-last decode would add a beat. It also flips `bank_sel` and mixes in write cycles and strobes pulsed in the middle of a burst. Swapped halves, the written bank being read, data driven on writes, or a restart in mid-burst would each show up as a data or ready miscompare.

// File: rtl/splice_pkg.sv
// Shared types for the stereo splicing read port.
// Assumes: nothing beyond a 3-bit state register.
package splice_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_SINGLE = 3'd2,
        ST_BRDY   = 3'd3,
        ST_BURST  = 3'd4,
        ST_BEND   = 3'd5,
        ST_END    = 3'd6
    } xfer_state_e;
endpackage

// File: rtl/splice_fsm.sv
// Transfer sequencer: tracks single and burst cycles from the strobe and
// burst-last inputs. Assumes both inputs are synchronous to clk.
module splice_fsm
    import splice_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ads_n,
    input  logic        blast_n,
    output xfer_state_e state,
    output logic        take,
    output logic        beat,
    output logic        step
);
    xfer_state_e nxt;

    // accept a new transfer only when idle or ending one
    assign take = ((state == ST_IDLE) || (state == ST_END)) && !ads_n;
    assign beat = (state == ST_SINGLE) || (state == ST_BURST);
    assign step = (state == ST_BURST);

    // next-state decode
    always_comb begin
        case (state)
            ST_IDLE:   nxt = !ads_n ? ST_START : ST_IDLE;
            ST_START:  nxt = !blast_n ? ST_SINGLE : ST_BRDY;
            ST_SINGLE: nxt = ST_END;
            ST_BRDY:   nxt = ST_BURST;
            ST_BURST:  nxt = !blast_n ? ST_BEND : ST_BURST;
            ST_BEND:   nxt = ST_END;
            ST_END:    nxt = !ads_n ? ST_START : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    p_strobe_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ads_n) |=> (state == ST_START));
    p_burst_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && blast_n) |=> (state == ST_BURST));
    p_end_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END && !ads_n) |=> (state == ST_START));
    p_ignore_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && blast_n && !ads_n) |=> (state == ST_BURST));
endmodule

// File: rtl/splice_addr.sv
// Word address counter and direction latch. Captures the bus address and
// direction at an accepted strobe; steps once per burst beat.
module splice_addr #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          step,
    input  logic [AW-1:0] bus_addr,
    input  logic          wr_rd,
    output logic [AW-1:0] addr_q,
    output logic          is_read
);
    // address and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            is_read <= 1'b0;
        end else if (take) begin
            addr_q  <= bus_addr;
            is_read <= wr_rd;
        end else if (step) begin
            addr_q  <= addr_q + 1'b1;
        end
    end

    p_addr_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (addr_q == $past(bus_addr)));
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !take) |=> (addr_q == AW'($past(addr_q) + 1'b1)));
endmodule

// File: rtl/splice_merge.sv
// Bank selection and word splicing. For each camera side picks the bank not
// being written; places side 0 (left) low and side 1 (right) high.
module splice_merge #(
    parameter int PW = 16
) (
    input  logic [1:0][PW-1:0] side_b0,
    input  logic [1:0][PW-1:0] side_b1,
    input  logic               bank_sel,
    input  logic               drive,
    output logic [2*PW-1:0]    word
);
    for (genvar s = 0; s < 2; s++) begin : g_side
        // read the bank opposite the one being written
        always_comb begin
            if (!drive)        word[s*PW +: PW] = '0;
            else if (bank_sel) word[s*PW +: PW] = side_b0[s];
            else               word[s*PW +: PW] = side_b1[s];
        end
    end
endmodule

// File: rtl/stereo_splice_rd.sv
// Stereo splicing read port. Serves local-bus reads by joining the left and
// right pixel at one word address from the banks not being written.
// Assumes asynchronous bank reads: data follows mem_addr in the same cycle.
module stereo_splice_rd
    import splice_pkg::*;
#(
    parameter int AW = 18,
    parameter int PW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_req,
    output logic            hold_ack,
    input  logic            ads_n,
    input  logic            blast_n,
    input  logic            wr_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bank_sel,
    input  logic [PW-1:0]   left_b0,
    input  logic [PW-1:0]   left_b1,
    input  logic [PW-1:0]   right_b0,
    input  logic [PW-1:0]   right_b1,
    output logic [AW-1:0]   mem_addr,
    output logic [2*PW-1:0] bus_data,
    output logic            rdy_n
);
    xfer_state_e       state;
    logic              take, beat, step, is_read;
    logic [1:0][PW-1:0] b0, b1;

    assign b0 = {right_b0, left_b0};
    assign b1 = {right_b1, left_b1};

    splice_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .blast_n(blast_n),
        .state(state), .take(take), .beat(beat), .step(step)
    );

    splice_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .take(take), .step(step),
        .bus_addr(bus_addr), .wr_rd(wr_rd),
        .addr_q(mem_addr), .is_read(is_read)
    );

    splice_merge #(.PW(PW)) u_merge (
        .side_b0(b0), .side_b1(b1), .bank_sel(bank_sel),
        .drive(beat && is_read), .word(bus_data)
    );

    assign rdy_n = !beat;

    // hold acknowledge follows the request one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) hold_ack <= 1'b0;
        else        hold_ack <= hold_req;
    end

    p_hold_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hold_ack == $past(hold_req)));
    p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_n |-> (bus_data == '0));
    p_single_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SINGLE) |=> rdy_n);
endmodule

// File: tb/stereo_splice_rd_tb.sv
module stereo_splice_rd_tb;
    localparam int AW = 18;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 1'b0, ads_n = 1'b1, blast_n = 1'b1, wr_rd = 1'b1, bank_sel = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [PW-1:0] left_b0, left_b1, right_b0, right_b1;
    logic hold_ack, rdy_n;
    logic [AW-1:0] mem_addr;
    logic [2*PW-1:0] bus_data;

    always #4 clk = ~clk;

    // bank contents: side 0 left, side 1 right; distinct per side, bank, address
    function automatic logic [PW-1:0] pat(input int side, input int bank, input logic [AW-1:0] a);
        return {side[0], bank[0], a[13:0]} ^ 16'h0A50;
    endfunction

    assign left_b0  = pat(0, 0, mem_addr);
    assign left_b1  = pat(0, 1, mem_addr);
    assign right_b0 = pat(1, 0, mem_addr);
    assign right_b1 = pat(1, 1, mem_addr);

    stereo_splice_rd #(.AW(AW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .ads_n(ads_n), .blast_n(blast_n), .wr_rd(wr_rd), .bus_addr(bus_addr),
        .bank_sel(bank_sel), .left_b0(left_b0), .left_b1(left_b1),
        .right_b0(right_b0), .right_b1(right_b1), .mem_addr(mem_addr),
        .bus_data(bus_data), .rdy_n(rdy_n)
    );

    // behavioural reference: phase names, address, direction, hold
    int            vectors = 0, errors = 0, cycles = 0;
    string         ph = "R1";
    string         mph = "idle";
    logic [AW-1:0] m_addr = '0;
    logic          m_read = 1'b0, m_hold = 1'b0, started = 1'b0;

    always @(posedge clk) begin
        started = 1'b1;
        cycles++;
        if (!rst_n) begin
            mph = "idle"; m_addr = '0; m_read = 1'b0; m_hold = 1'b0;
        end else begin
            m_hold = hold_req;
            if (mph == "idle" || mph == "end") begin
                if (!ads_n) begin mph = "start"; m_addr = bus_addr; m_read = wr_rd; end
                else mph = "idle";
            end else if (mph == "start") mph = blast_n ? "wait" : "one";
            else if (mph == "one") mph = "end";
            else if (mph == "wait") mph = "beat";
            else if (mph == "beat") begin
                m_addr = m_addr + 1'b1;
                if (!blast_n) mph = "bend";
            end else if (mph == "bend") mph = "end";
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // compare every output away from the edge
    always @(negedge clk) begin
        if (started) begin
            logic          exp_beat;
            logic [31:0]   exp_data;
            int            rb;
            exp_beat = (mph == "one") || (mph == "beat");
            rb = bank_sel ? 0 : 1;
            exp_data = (exp_beat && m_read) ? {pat(1, rb, m_addr), pat(0, rb, m_addr)} : 32'h0;
            vectors++;
            if (rdy_n !== !exp_beat) begin
                errors++;
                $display("FAIL %s (R3/R4 ready) in %s: rdy_n got %b expected %b", ph, mph, rdy_n, !exp_beat);
            end
            if (bus_data !== exp_data) begin
                errors++;
                $display("FAIL %s (R6/R7 data) in %s: got %h expected %h", ph, mph, bus_data, exp_data);
            end
            if (mem_addr !== m_addr) begin
                errors++;
                $display("FAIL %s (R5 address): got %h expected %h", ph, mem_addr, m_addr);
            end
            if (hold_ack !== m_hold) begin
                errors++;
                $display("FAIL %s (R2 hold): got %b expected %b", ph, hold_ack, m_hold);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        hold_req = cycles[2] ^ cycles[0];
    endtask

    task automatic idle(input int n);
        ads_n = 1'b1; blast_n = 1'b1;
        repeat (n) cyc();
    endtask

    task automatic single(input logic [AW-1:0] a, input logic rd);
        ads_n = 1'b0; bus_addr = a; wr_rd = rd; cyc();
        ads_n = 1'b1; blast_n = 1'b0; cyc();
        blast_n = 1'b1; cyc();
    endtask

    // n beats; optional stray strobe in the middle of the beats
    task automatic burst(input logic [AW-1:0] a, input logic rd, input int n, input bit stray);
        ads_n = 1'b0; bus_addr = a; wr_rd = rd; cyc();
        ads_n = 1'b1; blast_n = 1'b1; bus_addr = ~a; cyc();
        cyc();
        for (int i = 0; i < n - 1; i++) begin
            ads_n = !(stray && i == 0);
            cyc();
        end
        ads_n = 1'b1; blast_n = 1'b0; cyc();
        blast_n = 1'b1; cyc();
    endtask

    initial begin
        ph = "R1"; repeat (4) cyc(); rst_n = 1'b1; idle(3);
        ph = "R3"; single(18'h00123, 1'b1); idle(2);
        ph = "R7"; bank_sel = 1'b1; single(18'h00456, 1'b1); idle(1);
        ph = "R4"; burst(18'h01000, 1'b1, 5, 1'b0); idle(2);
        ph = "R4"; burst(18'h01F00, 1'b1, 1, 1'b0); idle(1);
        ph = "R5"; bank_sel = 1'b0; burst(18'h3FFFE, 1'b1, 4, 1'b0); idle(1);
        ph = "R8"; single(18'h00010, 1'b1); burst(18'h00200, 1'b1, 3, 1'b0);
        single(18'h00300, 1'b1); single(18'h00301, 1'b1); idle(2);
        ph = "R9"; single(18'h00040, 1'b0); burst(18'h00050, 1'b0, 3, 1'b0); idle(2);
        ph = "R10"; burst(18'h02000, 1'b1, 4, 1'b1); idle(3);
        ph = "R6"; for (int k = 0; k < 8; k++) begin
            bank_sel = k[0];
            burst(AW'(k * 977), 1'b1, 2 + k, 1'b0);
            if (k[1]) idle(1);
        end
        ph = "R2"; idle(6);
        ph = "R1"; rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule